// File: doc/BRIEF.md
# Core-Partitioned Shared Cache Directory

This block keeps the tags and valid bits of a shared set-associative cache that several cores use together. The ways of every set are cut into fixed, equal slices, one slice per core. A lookup from any core compares against every way of the indexed set, so a line brought in by one core is found by all the others. When the lookup misses, the line is installed only into a way of the requesting core's slice, and only a line in that slice can be pushed out.

The request carries a core number, a physical address and a valid strobe. The set is picked by the address bits directly above the byte offset within a line, and the rest of the upper bits form the tag. One cycle after a valid request the block presents its answer: hit or miss, the way that hit, the slice that holds the line, the way chosen for the fill, and the tag it displaced. The fill itself is written at the same clock edge, so the next request already sees it. The data array, the memory side and coherence belong to other blocks.

Top module: `partDir`

## Requirements
- R1: A synchronous active-high `rst` clears every valid bit and every replacement pointer; `respValid` is 0 during and right after reset, and the first miss by core c in any set then fills way c*WAYS_PER_CORE with `respEvictValid` 0.
- R2: The set index is `reqAddr[OFF_W +: SET_W]` and the tag is the bits above it, with OFF_W = log2(LINE_BYTES) and SET_W = log2(NUM_SETS); the offset bits have no effect on the result, and the same tag in another set does not hit.
- R3: For a request with `reqValid` high in cycle t, the response fields are shown with `respValid` high in cycle t+1; `respValid` is 0 in a cycle that follows no request.
- R4: A lookup compares all ways of the set; on a hit `respHit` is 1, `respHitWay` is the way holding the line and `respOwnerPart` is that way divided by WAYS_PER_CORE, whichever core asks.
- R5: Way w belongs to slice w / WAYS_PER_CORE; on a miss from core c, `respVictimWay` lies in c*WAYS_PER_CORE .. c*WAYS_PER_CORE+WAYS_PER_CORE-1, `respOwnerPart` equals c and `respHitWay` is 0.
- R6: On a miss, if the requester's slice has an invalid way, the fill takes the invalid way with the lowest number.
- R7: If the requester's slice is full, the fill takes local way p, where p is a pointer kept per set and per slice; after every fill into that slice (full or not) p becomes the filled local way plus one, wrapping to 0.
- R8: A fill from core c never removes or alters a line held in another core's slice; such lines keep hitting.
- R9: On a miss `respEvictValid` tells whether the chosen way held a line and `respEvictTag` gives its tag (0 when it held none); on a hit `respVictimWay`, `respEvictValid` and `respEvictTag` are all 0.
- R10: A hit writes nothing: no fill, no pointer movement, so a line is never held in two ways at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A lookup is presented this cycle |
| reqCore | input | CORE_W | Number of the requesting core |
| reqAddr | input | ADDR_W | Physical byte address |
| respValid | output | 1 | Response fields hold the answer to the previous cycle's request |
| respHit | output | 1 | Line was found in some way of the set |
| respHitWay | output | WAY_W | Way that hit (0 on a miss) |
| respOwnerPart | output | CORE_W | Slice holding the line after the request |
| respVictimWay | output | WAY_W | Way filled on a miss (0 on a hit) |
| respEvictValid | output | 1 | The filled way held a line before |
| respEvictTag | output | TAG_W | Tag of the displaced line (0 if none) |

## Verification
The assertions take for granted that `reqCore` is always below NUM_CORES while `reqValid` is high and that the request inputs carry known values; an out-of-range core would select ways past the last slice. The stimulus only draws core numbers from the legal range and keeps every request input driven even in idle cycles. Under those inputs the hit vector is one-hot-or-zero and every fill falls in the requester's slice, which the assertions inside the datapath and control guard.

// File: rtl/partDirPkg.sv
package partDirPkg;

  // Strobes sent from the control half to the storage half each cycle.
  typedef struct packed {
    logic lookup;   // a request is being looked up
    logic fill;     // write tag and valid into the chosen way
    logic bumpPtr;  // update the replacement pointer of the requester's slice
  } dirStrobe_t;

  // Index width that never collapses to zero bits.
  function automatic int idxWidth(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/partDirData.sv
module partDirData
  import partDirPkg::*;
#(
  parameter int NUM_CORES     = 2,
  parameter int WAYS_PER_CORE = 2,
  parameter int NUM_SETS      = 8,
  parameter int TAG_W         = 14,
  localparam int TOTAL_WAYS   = NUM_CORES * WAYS_PER_CORE,
  localparam int CORE_W       = idxWidth(NUM_CORES),
  localparam int WAY_W        = idxWidth(TOTAL_WAYS),
  localparam int LOCAL_W      = idxWidth(WAYS_PER_CORE),
  localparam int SET_W        = idxWidth(NUM_SETS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  dirStrobe_t                       strobe,
  input  logic [CORE_W-1:0]                lkCore,
  input  logic [SET_W-1:0]                 lkSet,
  input  logic [TAG_W-1:0]                 lkTag,
  input  logic [WAY_W-1:0]                 wrWay,
  input  logic [LOCAL_W-1:0]               newPtr,
  output logic [TOTAL_WAYS-1:0]            hitVec,
  output logic [TOTAL_WAYS-1:0]            rdValid,
  output logic [TOTAL_WAYS-1:0][TAG_W-1:0] rdTags,
  output logic [LOCAL_W-1:0]               rdPtr
);

  logic [TAG_W-1:0]                       tagMem   [NUM_SETS][TOTAL_WAYS];
  logic [TOTAL_WAYS-1:0]                  validMem [NUM_SETS];
  logic [NUM_CORES-1:0][LOCAL_W-1:0]      ptrMem   [NUM_SETS];

  // Valid bits and pointers: cleared by reset, written on a miss only.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validMem[s] <= '0;
        ptrMem[s]   <= '0;
      end
    end else begin
      if (strobe.fill)    validMem[lkSet][wrWay]  <= 1'b1;
      if (strobe.bumpPtr) ptrMem[lkSet][lkCore]   <= newPtr;
    end
  end

  // Tag storage needs no reset; valid bits qualify it.
  always_ff @(posedge clk) begin
    if (strobe.fill) tagMem[lkSet][wrWay] <= lkTag;
  end

  assign rdValid = validMem[lkSet];
  assign rdPtr   = ptrMem[lkSet][lkCore];

  // One comparator per way, across every slice of the set.
  for (genvar w = 0; w < TOTAL_WAYS; w++) begin : g_way
    assign rdTags[w] = tagMem[lkSet][w];
    assign hitVec[w] = validMem[lkSet][w] && (tagMem[lkSet][w] == lkTag);
  end

  AST_NO_DUP_COPY: assert property (@(posedge clk) disable iff (rst)
    strobe.lookup |-> $onehot0(hitVec))
    else $error("line held in more than one way"); // R10

  AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    strobe.fill |-> (hitVec == '0))
    else $error("fill issued while line is present"); // R10

  AST_FILL_OWN_PART: assert property (@(posedge clk) disable iff (rst)
    strobe.fill |-> ((int'(wrWay) / WAYS_PER_CORE) == int'(lkCore)))
    else $error("fill outside requester slice"); // R8

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    strobe.fill |=> (rdValid != '0 || $past(lkSet) != lkSet))
    else $error("filled way not valid afterwards"); // R6

endmodule

// File: rtl/partDirCtrl.sv
module partDirCtrl
  import partDirPkg::*;
#(
  parameter int NUM_CORES     = 2,
  parameter int WAYS_PER_CORE = 2,
  parameter int TAG_W         = 14,
  localparam int TOTAL_WAYS   = NUM_CORES * WAYS_PER_CORE,
  localparam int CORE_W       = idxWidth(NUM_CORES),
  localparam int WAY_W        = idxWidth(TOTAL_WAYS),
  localparam int LOCAL_W      = idxWidth(WAYS_PER_CORE)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reqValid,
  input  logic [CORE_W-1:0]                reqCore,
  input  logic [TOTAL_WAYS-1:0]            hitVec,
  input  logic [TOTAL_WAYS-1:0]            rdValid,
  input  logic [TOTAL_WAYS-1:0][TAG_W-1:0] rdTags,
  input  logic [LOCAL_W-1:0]               rdPtr,
  output dirStrobe_t                       strobe,
  output logic [WAY_W-1:0]                 wrWay,
  output logic [LOCAL_W-1:0]               newPtr,
  output logic                             respValid,
  output logic                             respHit,
  output logic [WAY_W-1:0]                 respHitWay,
  output logic [CORE_W-1:0]                respOwnerPart,
  output logic [WAY_W-1:0]                 respVictimWay,
  output logic                             respEvictValid,
  output logic [TAG_W-1:0]                 respEvictTag
);

  logic               hitAny;
  logic [WAY_W-1:0]   hitIdx;
  logic [CORE_W-1:0]  hitOwner;
  logic [WAY_W-1:0]   partBase;
  logic               freeAny;
  logic [LOCAL_W-1:0] freeIdx;
  logic [LOCAL_W-1:0] victimLocal;
  logic [WAY_W-1:0]   victimWay;

  assign hitAny = |hitVec;

  // Lowest matching way; at most one matches in a consistent directory.
  always_comb begin
    hitIdx = '0;
    for (int w = TOTAL_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitIdx = WAY_W'(w);
    end
  end

  assign hitOwner = CORE_W'(int'(hitIdx) / WAYS_PER_CORE);
  assign partBase = WAY_W'(int'(reqCore) * WAYS_PER_CORE);

  // Lowest invalid way inside the requester's slice.
  always_comb begin
    freeAny = 1'b0;
    freeIdx = '0;
    for (int l = WAYS_PER_CORE - 1; l >= 0; l--) begin
      if (!rdValid[int'(partBase) + l]) begin
        freeAny = 1'b1;
        freeIdx = LOCAL_W'(l);
      end
    end
  end

  assign victimLocal = freeAny ? freeIdx : rdPtr;
  assign victimWay   = partBase + WAY_W'(victimLocal);
  assign newPtr      = (int'(victimLocal) == WAYS_PER_CORE - 1) ? '0
                                                                : victimLocal + LOCAL_W'(1);
  assign wrWay       = victimWay;

  always_comb begin
    strobe.lookup  = reqValid;
    strobe.fill    = reqValid && !hitAny;
    strobe.bumpPtr = reqValid && !hitAny;
  end

  // Response register: answer appears one cycle after the request.
  always_ff @(posedge clk) begin
    if (rst) begin
      respValid      <= 1'b0;
      respHit        <= 1'b0;
      respHitWay     <= '0;
      respOwnerPart  <= '0;
      respVictimWay  <= '0;
      respEvictValid <= 1'b0;
      respEvictTag   <= '0;
    end else begin
      respValid <= reqValid;
      if (reqValid) begin
        respHit <= hitAny;
        if (hitAny) begin
          respHitWay     <= hitIdx;
          respOwnerPart  <= hitOwner;
          respVictimWay  <= '0;
          respEvictValid <= 1'b0;
          respEvictTag   <= '0;
        end else begin
          respHitWay     <= '0;
          respOwnerPart  <= reqCore;
          respVictimWay  <= victimWay;
          respEvictValid <= rdValid[victimWay];
          respEvictTag   <= rdValid[victimWay] ? rdTags[victimWay] : '0;
        end
      end
    end
  end

  AST_CORE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (int'(reqCore) < NUM_CORES))
    else $error("core number out of range"); // R5

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> respValid)
    else $error("response missing after request"); // R3

  AST_VICTIM_IN_OWN_PART: assert property (@(posedge clk) disable iff (rst)
    (respValid && !respHit) |-> ((int'(respVictimWay) / WAYS_PER_CORE) == int'($past(reqCore))))
    else $error("victim outside requester slice"); // R5

  AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
    (respValid && respHit) |-> (!respEvictValid && respVictimWay == '0))
    else $error("eviction reported on a hit"); // R9

endmodule

// File: rtl/partDir.sv
module partDir
  import partDirPkg::*;
#(
  parameter int NUM_CORES     = 2,
  parameter int WAYS_PER_CORE = 2,
  parameter int NUM_SETS      = 8,
  parameter int LINE_BYTES    = 64,
  parameter int ADDR_W        = 23,
  localparam int TOTAL_WAYS   = NUM_CORES * WAYS_PER_CORE,
  localparam int CORE_W       = idxWidth(NUM_CORES),
  localparam int WAY_W        = idxWidth(TOTAL_WAYS),
  localparam int LOCAL_W      = idxWidth(WAYS_PER_CORE),
  localparam int OFF_W        = idxWidth(LINE_BYTES),
  localparam int SET_W        = idxWidth(NUM_SETS),
  localparam int TAG_W        = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic              respHit,
  output logic [WAY_W-1:0]  respHitWay,
  output logic [CORE_W-1:0] respOwnerPart,
  output logic [WAY_W-1:0]  respVictimWay,
  output logic              respEvictValid,
  output logic [TAG_W-1:0]  respEvictTag
);

  dirStrobe_t                       strobe;
  logic [SET_W-1:0]                 lkSet;
  logic [TAG_W-1:0]                 lkTag;
  logic [WAY_W-1:0]                 wrWay;
  logic [LOCAL_W-1:0]               newPtr;
  logic [TOTAL_WAYS-1:0]            hitVec;
  logic [TOTAL_WAYS-1:0]            rdValid;
  logic [TOTAL_WAYS-1:0][TAG_W-1:0] rdTags;
  logic [LOCAL_W-1:0]               rdPtr;
  logic                             unusedOffsetBits;

  assign lkSet            = reqAddr[OFF_W +: SET_W];
  assign lkTag            = reqAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffsetBits = ^reqAddr[OFF_W-1:0];

  partDirData #(
    .NUM_CORES    (NUM_CORES),
    .WAYS_PER_CORE(WAYS_PER_CORE),
    .NUM_SETS     (NUM_SETS),
    .TAG_W        (TAG_W)
  ) uData (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .lkCore (reqCore),
    .lkSet  (lkSet),
    .lkTag  (lkTag),
    .wrWay  (wrWay),
    .newPtr (newPtr),
    .hitVec (hitVec),
    .rdValid(rdValid),
    .rdTags (rdTags),
    .rdPtr  (rdPtr)
  );

  partDirCtrl #(
    .NUM_CORES    (NUM_CORES),
    .WAYS_PER_CORE(WAYS_PER_CORE),
    .TAG_W        (TAG_W)
  ) uCtrl (
    .clk           (clk),
    .rst           (rst),
    .reqValid      (reqValid),
    .reqCore       (reqCore),
    .hitVec        (hitVec),
    .rdValid       (rdValid),
    .rdTags        (rdTags),
    .rdPtr         (rdPtr),
    .strobe        (strobe),
    .wrWay         (wrWay),
    .newPtr        (newPtr),
    .respValid     (respValid),
    .respHit       (respHit),
    .respHitWay    (respHitWay),
    .respOwnerPart (respOwnerPart),
    .respVictimWay (respVictimWay),
    .respEvictValid(respEvictValid),
    .respEvictTag  (respEvictTag)
  );

endmodule

// File: tb/sim_partDir.sv
`timescale 1ns/1ps
module sim_partDir;

  localparam int NC     = 2;
  localparam int WPC    = 2;
  localparam int SETS   = 4;
  localparam int LBYTES = 4;
  localparam int AW     = 10;
  localparam int TW     = NC * WPC;
  localparam int CW     = 1;
  localparam int WW     = 2;
  localparam int TAGW   = AW - 2 - 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reqValid = 1'b0;
  logic [CW-1:0]   reqCore = '0;
  logic [AW-1:0]   reqAddr = '0;
  logic            respValid;
  logic            respHit;
  logic [WW-1:0]   respHitWay;
  logic [CW-1:0]   respOwnerPart;
  logic [WW-1:0]   respVictimWay;
  logic            respEvictValid;
  logic [TAGW-1:0] respEvictTag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference state kept by the bench.
  int mTag [SETS][TW];
  bit mVal [SETS][TW];
  int mPtr [SETS][NC];

  always #2 clk = ~clk;

  partDir #(
    .NUM_CORES(NC), .WAYS_PER_CORE(WPC), .NUM_SETS(SETS),
    .LINE_BYTES(LBYTES), .ADDR_W(AW)
  ) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCore(reqCore), .reqAddr(reqAddr),
    .respValid(respValid), .respHit(respHit), .respHitWay(respHitWay),
    .respOwnerPart(respOwnerPart), .respVictimWay(respVictimWay),
    .respEvictValid(respEvictValid), .respEvictTag(respEvictTag)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mk(int tag, int set, int off);
    return tag * 16 + set * 4 + off;
  endfunction

  task automatic modelReset();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < TW; w++) begin mTag[s][w] = 0; mVal[s][w] = 0; end
      for (int c = 0; c < NC; c++) mPtr[s][c] = 0;
    end
  endtask

  task automatic applyReset();
    reqValid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
    @(negedge clk);
    chk("R1 respValid after reset", int'(respValid), 0);
  endtask

  // Drive one request, advance one cycle, compare every response field.
  task automatic doReq(int core, int addr);
    int set, tag, hw, base, loc, vic;
    bit hit, freeSeen;
    int eHitWay, eOwner, eVic, eEv, eEvTag;
    set = (addr / 4) % SETS;
    tag = addr / 16;
    hit = 0; hw = 0;
    for (int w = TW - 1; w >= 0; w--)
      if (mVal[set][w] && mTag[set][w] == tag) begin hit = 1; hw = w; end
    freeSeen = 0;
    if (hit) begin
      eHitWay = hw; eOwner = hw / WPC; eVic = 0; eEv = 0; eEvTag = 0;
    end else begin
      base = core * WPC;
      loc = -1;
      for (int l = WPC - 1; l >= 0; l--) if (!mVal[set][base + l]) loc = l;
      freeSeen = (loc >= 0);
      if (!freeSeen) loc = mPtr[set][core];
      vic = base + loc;
      eHitWay = 0; eOwner = core; eVic = vic;
      eEv = mVal[set][vic]; eEvTag = mVal[set][vic] ? mTag[set][vic] : 0;
      mVal[set][vic] = 1; mTag[set][vic] = tag;
      mPtr[set][core] = (loc + 1) % WPC;
    end
    reqValid = 1'b1;
    reqCore  = CW'(core);
    reqAddr  = AW'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3 respValid", int'(respValid), 1);
    chk("R4 hit flag", int'(respHit), int'(hit));
    chk(hit ? "R4 hit way" : "R5 hit way on miss", int'(respHitWay), eHitWay);
    chk(hit ? "R4 owner" : "R5 owner", int'(respOwnerPart), eOwner);
    chk(hit ? "R9 victim on hit" : (freeSeen ? "R6 victim" : "R7 victim"),
        int'(respVictimWay), eVic);
    chk("R9 evict valid", int'(respEvictValid), eEv);
    chk("R9 evict tag", int'(respEvictTag), eEvTag);
  endtask

  initial begin
    logic [15:0] lfsr;
    modelReset();
    applyReset();

    // R1: first miss lands in the slice's first way, nothing displaced.
    doReq(0, mk(3, 1, 0));
    chk("R1 first victim", int'(respVictimWay), 0);
    chk("R1 nothing evicted", int'(respEvictValid), 0);

    // R4 and R2: another core, other offset, same line hits in core 0's way.
    doReq(1, mk(3, 1, 3));
    chk("R2 offset ignored", int'(respHit), 1);
    chk("R4 cross-core hit owner", int'(respOwnerPart), 0);

    // R2: same tag, other set misses and goes to core 1's slice.
    doReq(1, mk(3, 2, 0));
    chk("R2 other set misses", int'(respHit), 0);
    chk("R5 core1 first way", int'(respVictimWay), 2);

    // R6 then R7 in core 0's slice of set 1.
    doReq(0, mk(4, 1, 0));
    chk("R6 lowest invalid", int'(respVictimWay), 1);
    doReq(0, mk(5, 1, 0));
    chk("R7 pointer victim", int'(respVictimWay), 0);
    chk("R7 evicted tag", int'(respEvictTag), 3);

    // R8: core 1 churns its own ways; core 0's lines stay.
    doReq(1, mk(6, 1, 0));
    doReq(1, mk(7, 1, 0));
    doReq(1, mk(8, 1, 0));
    chk("R7 core1 wrap victim", int'(respVictimWay), 2);
    chk("R7 core1 evicted tag", int'(respEvictTag), 6);
    doReq(1, mk(4, 1, 1));
    chk("R8 core0 line kept way1", int'(respHitWay), 1);
    doReq(0, mk(5, 1, 2));
    chk("R8 core0 line kept way0", int'(respHitWay), 0);

    // R10: hits leave pointer alone; next miss uses pointer 1.
    doReq(0, mk(4, 1, 0));
    doReq(0, mk(4, 1, 0));
    doReq(0, mk(9, 1, 0));
    chk("R10 pointer unchanged by hits", int'(respVictimWay), 1);
    chk("R10 evicted tag", int'(respEvictTag), 4);

    // R3: idle cycle gives no response.
    @(negedge clk);
    chk("R3 idle respValid", int'(respValid), 0);

    // Broad sweep with small tag space so hits and evictions both occur.
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      int tg;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tg = int'(lfsr[2:0]) + ((lfsr[9] && lfsr[10]) ? 32 : 0);
      doReq(int'(lfsr[3]), mk(tg, int'(lfsr[5:4]), int'(lfsr[7:6])));
      if (lfsr[11] && lfsr[12] && lfsr[13]) begin
        @(negedge clk);
        chk("R3 gap respValid", int'(respValid), 0);
      end
    end

    // R1: reset in mid-run clears lines and pointers.
    applyReset();
    doReq(1, mk(9, 1, 0));
    chk("R1 miss after reset", int'(respHit), 0);
    chk("R1 victim after reset", int'(respVictimWay), 2);
    doReq(0, mk(5, 1, 0));
    chk("R1 old line gone", int'(respHit), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule